// File: doc/BRIEF.md
# Buffered Bidirectional Synchronous Shift Port

This block is a byte-wide synchronous serial port that moves data one bit at a time over a shared clock and data pin pair. A mode bit picks the direction. When receiving, an external device drives the clock pin, and the block samples the data pin on each rising edge of that clock. When transmitting, the block drives the clock pin itself. It toggles that clock once for every underflow strobe from an outside timer, so one bit period takes two strobes. The fastest useful strobe spacing is two system clocks, which gives a bit rate of a quarter of the system clock.

On the CPU side there is one byte-wide data register, a sticky interrupt flag that clears on a status read, and a flag that shows a transmit byte is waiting. In transmit mode, a write to the data register starts a byte. If the CPU writes the next byte before the current one finishes, that byte follows at once with no idle clock period. The external clock and data inputs pass through a synchronizer before any edge is detected.

Top module: `syncser_port`

## Requirements
- R1: After reset, irq, buf_full, dat_rdata and both output enables are 0, and ser_clk_o and ser_dat_o are 1.
- R2: In receive mode (mode 0), each rising edge of ser_clk_i shifts ser_dat_i into the shifter, most significant bit first. After the eighth edge, dat_rdata holds the assembled byte.
- R3: The eighth received edge sets irq. irq stays set until a stat_rd pulse clears it.
- R4: In transmit mode (mode 1), a dat_wr sets buf_full in the next cycle. When the shifter is idle, the byte moves into the shifter one cycle later and buf_full returns to 0.
- R5: Transmitted bits leave most significant bit first. ser_dat_o changes only in the cycle where ser_clk_o falls, and then holds until the next fall.
- R6: While a byte is shifting, ser_clk_o toggles once for each tick pulse and at no other time, except when a mode write forces it high.
- R7: Once the eighth transmit clock pulse completes, irq is set. A byte written before then starts at once, so 2 bytes take exactly 32 toggles for 32 ticks.
- R8: When no byte is pending after the eighth pulse, ser_clk_o stays high and ser_dat_o keeps the level of the last bit sent, even if more ticks arrive.
- R9: A mode write clears the bit counter and leaves ser_clk_o high. Both output enables follow the mode (1 in transmit).
- R10: In receive mode, tick pulses have no effect, and ser_clk_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Strobe that loads the mode bit |
| mode_tx | input | 1 | New mode: 0 receive, 1 transmit |
| dat_wr | input | 1 | Strobe that writes the data register |
| dat_wdata | input | 8 | Byte to write |
| dat_rdata | output | 8 | Current data register contents |
| stat_rd | input | 1 | Status read strobe; clears irq |
| irq | output | 1 | Sticky byte-complete interrupt |
| buf_full | output | 1 | Transmit byte waiting to load |
| tick | input | 1 | Timer underflow strobe |
| ser_clk_i | input | 1 | Clock pin input (receive) |
| ser_dat_i | input | 1 | Data pin input (receive) |
| ser_clk_o | output | 1 | Clock pin output value |
| ser_clk_oe | output | 1 | Clock pin output enable |
| ser_dat_o | output | 1 | Data pin output value |
| ser_dat_oe | output | 1 | Data pin output enable |

## Verification
A received byte reaches dat_rdata and irq three system clocks after the eighth pin rising edge. Two of those cycles are the synchronizer and one is the update register. The bench therefore waits at least three cycles after each received byte before it checks. In transmit mode, buf_full rises one cycle after a write and falls one cycle later. Each tick changes ser_clk_o one cycle later, and ser_dat_o moves in that same cycle. A monitor samples the pins at the falling system-clock edge and captures a bit on every observed fall of ser_clk_o. Toggle counts are compared only after the tick sequence has fully drained.

// File: rtl/syncser_pkg.sv
package syncser_pkg;
    typedef enum logic {
        MODE_RX = 1'b0,
        MODE_TX = 1'b1
    } ser_mode_e;
endpackage

// File: rtl/syncser_sync.sv
module syncser_sync #(
    parameter int          STAGES = 2,
    parameter int          W      = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= RST_VAL;
            end else if (g == 0) begin
                stage_q[g] <= d;
            end else begin
                stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/syncser_port.sv
module syncser_port
    import syncser_pkg::*;
#(
    parameter int W         = 8,
    parameter int SYNC_STG  = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_wr,
    input  logic         mode_tx,
    input  logic         dat_wr,
    input  logic [W-1:0] dat_wdata,
    output logic [W-1:0] dat_rdata,
    input  logic         stat_rd,
    output logic         irq,
    output logic         buf_full,
    input  logic         tick,
    input  logic         ser_clk_i,
    input  logic         ser_dat_i,
    output logic         ser_clk_o,
    output logic         ser_clk_oe,
    output logic         ser_dat_o,
    output logic         ser_dat_oe
);
    localparam int          CW   = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        ser_mode_e      mode;
        logic [W-1:0]   sh;
        logic [CW-1:0]  cnt;
        logic [W-1:0]   data;
        logic           pend;
        logic           busy;
        logic           sclk;
        logic           sdo;
        logic           irq;
        logic           ck_prev;
    } port_state_t;

    port_state_t s_q, s_d;
    logic [1:0]  pins_s;
    logic        ck_s, dt_s, rise, ld;

    syncser_sync #(.STAGES(SYNC_STG), .W(2), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_clk_i, ser_dat_i}),
        .q     (pins_s)
    );

    assign ck_s = pins_s[1];
    assign dt_s = pins_s[0];

    always_comb begin
        s_d        = s_q;
        ld         = 1'b0;
        rise       = ck_s & ~s_q.ck_prev;
        s_d.ck_prev = ck_s;

        if (stat_rd) s_d.irq = 1'b0;

        if (dat_wr) s_d.data = dat_wdata;

        if (mode_wr) begin
            s_d.mode = ser_mode_e'(mode_tx);
            s_d.cnt  = '0;
            s_d.busy = 1'b0;
            s_d.sclk = 1'b1;
        end else if (s_q.mode == MODE_RX) begin
            if (rise) begin
                s_d.sh = {s_q.sh[W-2:0], dt_s};
                if (s_q.cnt == LAST) begin
                    s_d.data = {s_q.sh[W-2:0], dt_s};
                    s_d.irq  = 1'b1;
                    s_d.cnt  = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end else begin
            if (s_q.busy && tick) begin
                s_d.sclk = ~s_q.sclk;
                if (s_q.sclk) begin
                    s_d.sdo = s_q.sh[W-1];
                    s_d.sh  = {s_q.sh[W-2:0], 1'b0};
                end else if (s_q.cnt == LAST) begin
                    s_d.irq = 1'b1;
                    s_d.cnt = '0;
                    if (s_q.pend) ld = 1'b1;
                    else          s_d.busy = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end else if (!s_q.busy && s_q.pend) begin
                ld = 1'b1;
            end
            if (ld) begin
                s_d.sh   = s_q.data;
                s_d.pend = 1'b0;
                s_d.busy = 1'b1;
                s_d.cnt  = '0;
            end
        end

        if (dat_wr && s_q.mode == MODE_TX) s_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.mode    <= MODE_RX;
            s_q.sclk    <= 1'b1;
            s_q.sdo     <= 1'b1;
            s_q.ck_prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign dat_rdata  = s_q.data;
    assign irq        = s_q.irq;
    assign buf_full   = s_q.pend;
    assign ser_clk_o  = s_q.sclk;
    assign ser_dat_o  = s_q.sdo;
    assign ser_clk_oe = (s_q.mode == MODE_TX);
    assign ser_dat_oe = (s_q.mode == MODE_TX);
endmodule

// File: rtl/syncser_port_chk.sv
module syncser_port_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_wr,
    input logic dat_wr,
    input logic stat_rd,
    input logic tick,
    input logic irq,
    input logic buf_full,
    input logic ser_clk_o,
    input logic ser_clk_oe,
    input logic ser_dat_o
);
    assert_irq_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !stat_rd |=> irq);

    assert_wr_pends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dat_wr && ser_clk_oe |=> buf_full);

    assert_dat_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_dat_o) |-> $fell(ser_clk_o));

    assert_clk_by_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_clk_o) |-> ($past(tick) || $past(mode_wr)));

    assert_mode_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> ser_clk_o);

    assert_rx_clk_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_clk_oe && !$past(ser_clk_oe) |-> ser_clk_o);
endmodule

bind syncser_port syncser_port_chk u_chk (.*);

// File: tb/sim_syncser_port.sv
`timescale 1ns/1ps
module sim_syncser_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 0, mode_tx = 0, dat_wr = 0, stat_rd = 0, tick = 0;
    logic [7:0] dat_wdata = '0;
    logic [7:0] dat_rdata;
    logic       irq, buf_full, ser_clk_o, ser_clk_oe, ser_dat_o, ser_dat_oe;
    logic       ser_clk_i = 1'b1, ser_dat_i = 1'b1;

    int n_chk = 0, n_bad = 0;
    int tog = 0, mon_n = 0, n_got = 0;
    logic [7:0] mon_sh = '0;
    logic [7:0] got [64];
    logic       prev_co = 1'b1;

    always #2.5 clk = ~clk;

    syncser_port u0 (.*);

    function automatic bit exp_bit(logic [7:0] b, int k);
        return b[7-k];
    endfunction

    function automatic logic [7:0] exp_byte(logic [7:0] b);
        logic [7:0] r = '0;
        for (int k = 0; k < 8; k++) r = {r[6:0], exp_bit(b, k)};
        return r;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(bit tx);
        mode_wr = 1; mode_tx = tx; cyc(1); mode_wr = 0;
    endtask

    task automatic wr(logic [7:0] b);
        dat_wr = 1; dat_wdata = b; cyc(1); dat_wr = 0;
    endtask

    task automatic clr_irq();
        stat_rd = 1; cyc(1); stat_rd = 0;
    endtask

    task automatic tick_n(int n);
        repeat (n) begin tick = 1; cyc(1); tick = 0; cyc(1); end
    endtask

    task automatic rx_bits(logic [7:0] b, int n);
        for (int i = 7; i > 7 - n; i--) begin
            ser_dat_i = b[i]; ser_clk_i = 0; cyc(3);
            ser_clk_i = 1; cyc(3);
        end
        cyc(3);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (ser_clk_o !== prev_co) tog++;
            if (prev_co && !ser_clk_o) begin
                mon_sh = {mon_sh[6:0], ser_dat_o};
                mon_n++;
                if (mon_n == 8) begin
                    got[n_got] = mon_sh;
                    n_got++;
                    mon_n = 0;
                end
            end
            prev_co = ser_clk_o;
        end
    end

    task automatic mon_reset();
        tog = 0; n_got = 0; mon_n = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic [7:0] tx [8];
        void'($urandom(32'd2024));
        cyc(3); rst_n = 1; cyc(1);

        // R1 reset state
        chk(irq == 0 && buf_full == 0 && dat_rdata == 0, "R1 flags", {irq, buf_full, dat_rdata}, 0);
        chk(ser_clk_o && ser_dat_o && !ser_clk_oe && !ser_dat_oe, "R1 pins",
            {ser_clk_o, ser_dat_o, ser_clk_oe, ser_dat_oe}, 4'b1100);

        // R10 ticks ignored in receive mode
        tick_n(4);
        chk(ser_clk_o == 1 && tog == 0, "R10 no clock in rx", tog, 0);

        // R2/R3 directed and random receive
        rx_bits(8'h81, 8);
        chk(dat_rdata == exp_byte(8'h81), "R2 rx 81", dat_rdata, 8'h81);
        chk(irq == 1, "R3 irq set", irq, 1);
        cyc(5);
        chk(irq == 1, "R3 irq sticky", irq, 1);
        clr_irq();
        chk(irq == 0, "R3 irq cleared", irq, 0);
        for (int r = 0; r < 6; r++) begin
            b = 8'($urandom);
            rx_bits(b, 8);
            chk(dat_rdata == exp_byte(b), "R2 rx random", dat_rdata, b);
            chk(irq == 1, "R3 rx random irq", irq, 1);
            clr_irq();
        end

        // R9 partial byte then mode change clears the counter
        rx_bits(8'hFF, 3);
        set_mode(1);
        chk(ser_clk_oe && ser_dat_oe && ser_clk_o, "R9 tx idle", {ser_clk_oe, ser_dat_oe, ser_clk_o}, 3'b111);
        set_mode(0);
        chk(!ser_clk_oe && ser_clk_o, "R9 rx oe", ser_clk_oe, 0);
        rx_bits(8'hA5, 8);
        chk(dat_rdata == 8'hA5, "R9 counter reset", dat_rdata, 8'hA5);
        clr_irq();

        // R4..R8 directed transmit, back to back
        set_mode(1);
        mon_reset();
        wr(8'hC3);
        chk(buf_full == 1, "R4 pend after write", buf_full, 1);
        cyc(1);
        chk(buf_full == 0, "R4 pend cleared on load", buf_full, 0);
        wr(8'h5A);
        tick_n(16);
        chk(irq == 1, "R7 irq after first byte", irq, 1);
        clr_irq();
        tick_n(16);
        chk(n_got == 2 && got[0] == 8'hC3, "R5 first byte", got[0], 8'hC3);
        chk(got[1] == 8'h5A, "R5 second byte", got[1], 8'h5A);
        chk(tog == 32, "R7 no gap", tog, 32);
        chk(irq == 1 && buf_full == 0, "R7 irq second", irq, 1);
        tick_n(4);
        chk(tog == 32 && ser_clk_o == 1, "R8 clock idle high", tog, 32);
        chk(ser_dat_o == exp_bit(8'h5A, 7), "R8 last bit held", ser_dat_o, 0);
        clr_irq();

        // R5/R6/R7 random transmit stream
        for (int k = 0; k < 6; k++) tx[k] = 8'($urandom);
        mon_reset();
        wr(tx[0]);
        cyc(2);
        fork
            tick_n(16 * 6 + 4);
            begin
                for (int k = 1; k < 6; k++) begin
                    while (buf_full) cyc(1);
                    wr(tx[k]);
                end
            end
        join
        chk(n_got == 6, "R5 byte count", n_got, 6);
        for (int k = 0; k < 6; k++)
            chk(got[k] == exp_byte(tx[k]), "R5 random byte", got[k], tx[k]);
        chk(tog == 16 * 6, "R6 toggles per tick", tog, 96);
        chk(ser_clk_o == 1 && ser_dat_o == exp_bit(tx[5], 7), "R8 idle after stream",
            {ser_clk_o, ser_dat_o}, {1'b1, tx[5][0]});

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule